// File: doc/BRIEF.md
# Checkpointed Register File

This block is a register file in which every architectural register keeps two values: a working value, which the pipeline reads and writes, and a saved value, which holds the state at the last checkpoint. A single commit strobe saves every working value in one clock. A single rollback strobe returns every working value to its saved value in one clock. Speculative execution can therefore run ahead freely. The controlling logic then either keeps the results or throws them away, with no per-register bookkeeping.

There are two registered read ports and one write port. A parameter mask marks some registers as scratch. Scratch registers have no saved copy, and neither strobe affects them. They suit temporaries that never form part of the recoverable state.

Top module: `ckpt_regfile`

## Requirements
- R1: Each read port is registered. The data for an address presented before a rising edge appears after that edge. It is the working value as it stood before any update made at the same edge, so a read and a write to the same register in one cycle return the old value.
- R2: A write with no strobe changes only the working value of the addressed register. Its saved value is unchanged, so a later rollback removes the write.
- R3: A commit copies every non-scratch working value into its saved value in one cycle. A following rollback then returns exactly those values.
- R4: A rollback restores every non-scratch working value from its saved value in one cycle. A read issued in the next cycle already sees the restored value.
- R5: A write issued in the same cycle as a commit is part of the new checkpoint.
- R6: When commit and rollback are both asserted, rollback takes effect. The commit is ignored, a write to a non-scratch register in that cycle is discarded, and the saved values stay as they were.
- R7: Reset (synchronous, active high) clears all working values, all saved values and both read outputs. A rollback straight after reset therefore yields zeros.
- R8: A register whose bit is set in SCRATCH_MASK (bit i for register i) ignores commit and rollback. A write to it always takes effect, even in a rollback cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW | Write register index |
| wr_data | input | WIDTH | Write data |
| ckpt_save | input | 1 | Commit strobe: save all working values |
| ckpt_restore | input | 1 | Rollback strobe: restore all working values |
| rd_addr_a | input | AW | Read port A index |
| rd_data_a | output | WIDTH | Read port A data, registered |
| rd_addr_b | input | AW | Read port B index |
| rd_data_b | output | WIDTH | Read port B data, registered |

## Verification
A saved value that is wrong stays hidden until the next rollback. After the rollback it shows on the first read of that register, one cycle later. The bench therefore follows writes and commits with rollbacks and full read-back sweeps, so that a corrupt checkpoint cannot sit unobserved. A strobe-priority or scratch-mask error shows on the first read issued after the cycle in which the strobes were applied.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;

  typedef enum logic [1:0] {
    CK_NONE    = 2'd0,
    CK_SAVE    = 2'd1,
    CK_RESTORE = 2'd2
  } ckpt_op_e;

  // Rollback takes priority over commit.
  function automatic ckpt_op_e decode_op(input logic save, input logic restore);
    if (restore)   return CK_RESTORE;
    else if (save) return CK_SAVE;
    else           return CK_NONE;
  endfunction

endpackage

// File: rtl/ckpt_cell.sv
module ckpt_cell
  import ckpt_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit SCRATCH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  input  ckpt_op_e         op,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] work_q;
  logic [WIDTH-1:0] next_work;

  assign next_work = we ? wdata : work_q;
  assign q = work_q;

  generate
    if (SCRATCH) begin : g_scratch
      always_ff @(posedge clk) begin
        if (rst) work_q <= '0;
        else     work_q <= next_work;
      end

      p_scratch_write_r8: assert property (@(posedge clk) disable iff (rst)
        we |=> (q == $past(wdata)));
    end else begin : g_shadowed
      logic [WIDTH-1:0] save_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          work_q <= '0;
          save_q <= '0;
        end else begin
          case (op)
            CK_RESTORE: work_q <= save_q;
            CK_SAVE: begin
              work_q <= next_work;
              save_q <= next_work;
            end
            default: work_q <= next_work;
          endcase
        end
      end

      p_restore_r4: assert property (@(posedge clk) disable iff (rst)
        (op == CK_RESTORE) |=> (q == $past(save_q)));
      p_restore_keeps_save_r6: assert property (@(posedge clk) disable iff (rst)
        (op == CK_RESTORE) |=> $stable(save_q));
      p_commit_match_r3: assert property (@(posedge clk) disable iff (rst)
        (op == CK_SAVE) |=> (save_q == q));
      p_write_only_work_r2: assert property (@(posedge clk) disable iff (rst)
        (we && op == CK_NONE) |=> ($stable(save_q) && q == $past(wdata)));
      p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (save_q == '0 && q == '0));
    end
  endgenerate

endmodule

// File: rtl/ckpt_read_port.sv
module ckpt_read_port #(
  parameter int NREGS = 64,
  parameter int WIDTH = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NREGS*WIDTH-1:0] regs_flat,
  input  logic [AW-1:0]          addr,
  output logic [WIDTH-1:0]       rdata
);

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= regs_flat[addr*WIDTH +: WIDTH];
  end

  p_rd_reset_r7: assert property (@(posedge clk) rst |=> (rdata == '0));

endmodule

// File: rtl/ckpt_regfile.sv
module ckpt_regfile
  import ckpt_pkg::*;
#(
  parameter int              NREGS        = 64,
  parameter int              WIDTH        = 32,
  parameter logic [NREGS-1:0] SCRATCH_MASK = {8'hFF, {(NREGS-8){1'b0}}},
  localparam int             AW           = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             ckpt_save,
  input  logic             ckpt_restore,
  input  logic [AW-1:0]    rd_addr_a,
  output logic [WIDTH-1:0] rd_data_a,
  input  logic [AW-1:0]    rd_addr_b,
  output logic [WIDTH-1:0] rd_data_b
);

  ckpt_op_e               op;
  logic [NREGS*WIDTH-1:0] regs_flat;

  assign op = decode_op(ckpt_save, ckpt_restore);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [WIDTH-1:0] cell_q;
    logic             sel;

    assign sel = wr_en && (wr_addr == AW'(i));

    ckpt_cell #(
      .WIDTH  (WIDTH),
      .SCRATCH(SCRATCH_MASK[i])
    ) u_cell (
      .clk  (clk),
      .rst  (rst),
      .we   (sel),
      .wdata(wr_data),
      .op   (op),
      .q    (cell_q)
    );

    assign regs_flat[i*WIDTH +: WIDTH] = cell_q;
  end

  ckpt_read_port #(.NREGS(NREGS), .WIDTH(WIDTH)) u_rd_a (
    .clk(clk), .rst(rst), .regs_flat(regs_flat), .addr(rd_addr_a), .rdata(rd_data_a)
  );

  ckpt_read_port #(.NREGS(NREGS), .WIDTH(WIDTH)) u_rd_b (
    .clk(clk), .rst(rst), .regs_flat(regs_flat), .addr(rd_addr_b), .rdata(rd_data_b)
  );

  // R1: both ports see one register array, so equal addresses give equal data.
  p_ports_agree_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == rd_addr_b) |=> (rd_data_a == rd_data_b));

endmodule

// File: tb/ckpt_regfile_test.sv
module ckpt_regfile_test;

  localparam int N  = 8;
  localparam int W  = 8;
  localparam int AW = $clog2(N);
  localparam logic [N-1:0] MASK = 8'b1100_0000;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en, ckpt_save, ckpt_restore;
  logic [AW-1:0] wr_addr, rd_addr_a, rd_addr_b;
  logic [W-1:0]  wr_data, rd_data_a, rd_data_b;

  int vectors = 0;
  int errors  = 0;
  logic [W-1:0] m_work [N];
  logic [W-1:0] m_save [N];

  always #4 clk = ~clk;

  ckpt_regfile #(.NREGS(N), .WIDTH(W), .SCRATCH_MASK(MASK)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ckpt_save(ckpt_save), .ckpt_restore(ckpt_restore),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, update model, check after the edge.
  task automatic step(input string tag, input logic we, input int wa, input logic [W-1:0] wd,
                      input logic sv, input logic rb, input int ra, input int rbx);
    logic [W-1:0] ea, eb;
    @(negedge clk);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    ckpt_save = sv; ckpt_restore = rb;
    rd_addr_a = AW'(ra); rd_addr_b = AW'(rbx);
    ea = m_work[ra];
    eb = m_work[rbx];
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] nw;
      nw = (we && wa == i) ? wd : m_work[i];
      if (MASK[i])  m_work[i] = nw;
      else if (rb)  m_work[i] = m_save[i];
      else if (sv) begin m_work[i] = nw; m_save[i] = nw; end
      else          m_work[i] = nw;
    end
    @(posedge clk);
    #1;
    chk(tag, rd_data_a, ea);
    chk(tag, rd_data_b, eb);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < N; i++) step(tag, 1'b0, 0, '0, 1'b0, 1'b0, i, N-1-i);
  endtask

  initial begin
    #(8*200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_addr = '0; wr_data = '0;
    ckpt_save = 0; ckpt_restore = 0; rd_addr_a = '0; rd_addr_b = '0;
    for (int i = 0; i < N; i++) begin m_work[i] = '0; m_save[i] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R7", rd_data_a, '0);
    chk("R7", rd_data_b, '0);
    @(negedge clk); rst = 1'b0;

    // R7: rollback immediately after reset gives zeros
    step("R7", 1'b0, 0, '0, 1'b0, 1'b1, 0, 7);
    sweep("R7");

    // R1: write every register, read back, and read-during-write returns the old value
    for (int i = 0; i < N; i++) step("R1", 1'b1, i, W'(8'h10 + i*3), 1'b0, 1'b0, i, i);
    sweep("R1");

    // R2: uncommitted writes vanish on rollback (shadowed only)
    step("R2", 1'b0, 0, '0, 1'b0, 1'b1, 0, 6);
    sweep("R2");

    // R5: write in the commit cycle is in the checkpoint
    for (int i = 0; i < N; i++) step("R3", 1'b1, i, W'(8'hA0 + i), 1'b0, 1'b0, 0, 1);
    step("R5", 1'b1, 2, 8'h5C, 1'b1, 1'b0, 2, 3);
    // R3/R4: overwrite everything, then rollback returns the committed set
    for (int i = 0; i < N; i++) step("R4", 1'b1, i, W'(8'hE0 + i), 1'b0, 1'b0, i, 0);
    step("R4", 1'b0, 0, '0, 1'b0, 1'b1, 2, 7);
    sweep("R3");

    // R6: both strobes with a write: rollback wins, save unchanged
    step("R6", 1'b1, 1, 8'h77, 1'b0, 1'b0, 1, 1);
    step("R6", 1'b1, 1, 8'h99, 1'b1, 1'b1, 1, 0);
    step("R6", 1'b1, 0, 8'h33, 1'b0, 1'b0, 1, 0);
    step("R6", 1'b0, 0, '0, 1'b0, 1'b1, 1, 0);
    sweep("R6");

    // R8: scratch register writes land during rollback and survive it
    step("R8", 1'b1, 6, 8'h66, 1'b0, 1'b1, 6, 7);
    step("R8", 1'b1, 7, 8'h71, 1'b1, 1'b0, 7, 6);
    step("R8", 1'b1, 7, 8'h72, 1'b0, 1'b0, 7, 6);
    step("R8", 1'b0, 0, '0, 1'b0, 1'b1, 7, 6);
    sweep("R8");

    // Mixed sweep over all operation combinations
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom;
      step("R2", r[0], r[6:4], W'(r[23:16]), r[1] & r[2], r[3] & r[9], r[12:10], r[15:13]);
    end
    sweep("R4");

    // R7: reset mid-run clears everything including saved values
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < N; i++) begin m_work[i] = '0; m_save[i] = '0; end
    step("R7", 1'b0, 0, '0, 1'b0, 1'b1, 0, 5);
    sweep("R7");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule